// File: doc/BRIEF.md
# Overrun Discard and Line Resync Controller

This controller takes over a capture DMA engine when its data FIFO overflows after a bus write has already been committed to a target address. The target pointer and the FIFO contents no longer agree at that point. The controller therefore asks for the transaction to end as soon as the target finally answers, and it raises a one-cycle slow-target interrupt event. From then on it pops and throws away FIFO words. It keeps discarding across any prefetched instructions. If the instruction supply runs dry, it keeps discarding for the rest of the scan line.

Each end-of-line marker that the controller pops while discarding counts as one thrown-away line. The count saturates at its maximum value. The first such marker starts a bus request. The instruction side reports the end-of-line status of each instruction it steps past. The controller leaves discard mode only in a cycle where the bus is granted and its own discarded-line count equals the instruction-side count. This keeps the data and the program aligned line for line.

The FIFO side is a valid/ready stream. The controller raises `fifo_ready` only while it is discarding, and a word counts as popped only in a cycle where both `fifo_valid` and `fifo_ready` are high. Outside discard mode it never pops, so the normal write path keeps ownership of the FIFO.

Top module: `ovr_resync_ctrl`

## Requirements
- R1: After reset, every output is 0: `term_req`, `slow_irq`, `discard_en`, `fifo_ready`, `tail_drop`, `bus_req` and `lines_dropped`.
- R2: `ovf` has no effect while `wait_target` is low: `discard_en` and `term_req` stay 0.
- R3: If `ovf` and `wait_target` are both high at a clock edge, the controller arms. `term_req` then stays low until `tgt_ack` is sampled high. After that edge, `term_req` is high for exactly one cycle.
- R4: `slow_irq` is high in exactly the cycle where `term_req` is high.
- R5: From the cycle in which `term_req` is high until the controller exits, `discard_en` and `fifo_ready` are both 1.
- R6: If `instr_done` is sampled while `instr_avail` is high during discard, discarding continues and `tail_drop` stays 0.
- R7: If `instr_done` is sampled while `instr_avail` is low during discard, `tail_drop` becomes 1 and discarding continues until an end-of-line marker is popped.
- R8: A popped end-of-line marker (`fifo_valid`, `fifo_ready` and `fifo_eol` all 1) increments `lines_dropped` by one in the next cycle. It also sets `bus_req` to 1 and `tail_drop` to 0.
- R9: `lines_dropped` and the internal instruction-side count saturate at 2^LINE_W-1; they do not wrap.
- R10: Discard ends only at an edge where `bus_req`, `bus_gnt` and the equality of `lines_dropped` with the count of `ins_eol` pulses since arming all hold. A grant while the counts differ leaves `discard_en` at 1.
- R11: After discard ends, `lines_dropped` keeps its value. The next arming clears it to 0.
- R12: Popping a word whose `fifo_eol` is 0 leaves `lines_dropped` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_target | input | 1 | A committed write is waiting for its target |
| ovf | input | 1 | FIFO overflow flag |
| tgt_ack | input | 1 | Target has responded |
| bus_gnt | input | 1 | Bus granted to this engine |
| instr_avail | input | 1 | A prefetched instruction is ready |
| instr_done | input | 1 | Current instruction exhausted |
| ins_eol | input | 1 | Instruction side stepped past an end-of-line status |
| fifo_valid | input | 1 | FIFO has a word to pop |
| fifo_eol | input | 1 | Word at FIFO head carries an end-of-line marker |
| fifo_ready | output | 1 | Controller pops (and drops) the head word |
| term_req | output | 1 | One-cycle request to end the current transaction |
| slow_irq | output | 1 | One-cycle slow-target interrupt event |
| discard_en | output | 1 | Discard mode active |
| tail_drop | output | 1 | Discarding the rest of the line with no instructions left |
| bus_req | output | 1 | Requesting the bus to resynchronise |
| lines_dropped | output | LINE_W | Saturating count of discarded lines |

## Verification
The assertions assume that `tgt_ack` is meaningful only while the controller is armed, and that `bus_gnt` reaches the controller only as a response to `bus_req`. The directed stimulus raises `tgt_ack` only after arming and grants the bus only once the resync request is up. It pulses `instr_done` and `ins_eol` for single cycles at a time, or holds them on purpose in the saturation scenario. It also lowers `fifo_valid` before it exercises the exit, so that no end-of-line pop lands in the same cycle as the exit decision.

// File: rtl/ovr_resync_pkg.sv
package ovr_resync_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ARMED,
    RS_DROP_INSTR,
    RS_DROP_LINE,
    RS_RESYNC
  } rs_state_e;
endpackage

// File: rtl/rs_sat_counter.sv
module rs_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != TOP)   q <= q + 1'b1;
  end
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import ovr_resync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_target,
  input  logic      ovf,
  input  logic      tgt_ack,
  input  logic      instr_avail,
  input  logic      instr_done,
  input  logic      eol_pop,
  input  logic      bus_gnt,
  input  logic      counts_equal,
  output rs_state_e state,
  output logic      arm,
  output logic      term_pulse,
  output logic      irq_pulse
);
  rs_state_e nxt;
  logic      fire;

  assign arm  = (state == RS_IDLE) && wait_target && ovf;
  assign fire = (state == RS_ARMED) && tgt_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      RS_IDLE:       if (arm) nxt = RS_ARMED;
      RS_ARMED:      if (tgt_ack) nxt = RS_DROP_INSTR;
      RS_DROP_INSTR: begin
        if (eol_pop)                        nxt = RS_RESYNC;
        else if (instr_done && !instr_avail) nxt = RS_DROP_LINE;
      end
      RS_DROP_LINE:  if (eol_pop) nxt = RS_RESYNC;
      RS_RESYNC:     if (bus_gnt && counts_equal) nxt = RS_IDLE;
      default:       nxt = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RS_IDLE;
      term_pulse <= 1'b0;
      irq_pulse  <= 1'b0;
    end else begin
      state      <= nxt;
      term_pulse <= fire;
      irq_pulse  <= fire;
    end
  end
endmodule

// File: rtl/ovr_resync_ctrl.sv
module ovr_resync_ctrl
  import ovr_resync_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_target,
  input  logic              ovf,
  input  logic              tgt_ack,
  input  logic              bus_gnt,
  input  logic              instr_avail,
  input  logic              instr_done,
  input  logic              ins_eol,
  input  logic              fifo_valid,
  input  logic              fifo_eol,
  output logic              fifo_ready,
  output logic              term_req,
  output logic              slow_irq,
  output logic              discard_en,
  output logic              tail_drop,
  output logic              bus_req,
  output logic [LINE_W-1:0] lines_dropped
);
  rs_state_e         state;
  logic              arm;
  logic              dropping;
  logic              eol_pop;
  logic              ins_inc;
  logic [LINE_W-1:0] ins_cnt;

  assign dropping = (state == RS_DROP_INSTR) || (state == RS_DROP_LINE) ||
                    (state == RS_RESYNC);
  assign eol_pop  = dropping && fifo_valid && fifo_eol;
  assign ins_inc  = ins_eol && (dropping || state == RS_ARMED);

  rs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_target (wait_target),
    .ovf         (ovf),
    .tgt_ack     (tgt_ack),
    .instr_avail (instr_avail),
    .instr_done  (instr_done),
    .eol_pop     (eol_pop),
    .bus_gnt     (bus_gnt),
    .counts_equal(lines_dropped == ins_cnt),
    .state       (state),
    .arm         (arm),
    .term_pulse  (term_req),
    .irq_pulse   (slow_irq)
  );

  rs_sat_counter #(.W(LINE_W)) u_drop_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .inc   (eol_pop),
    .q     (lines_dropped)
  );

  rs_sat_counter #(.W(LINE_W)) u_ins_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arm),
    .inc   (ins_inc),
    .q     (ins_cnt)
  );

  assign discard_en = dropping;
  assign fifo_ready = dropping;
  assign tail_drop  = (state == RS_DROP_LINE);
  assign bus_req    = (state == RS_RESYNC);
endmodule

// File: rtl/ovr_resync_checker.sv
module ovr_resync_checker #(
  parameter int LINE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tgt_ack,
  input logic              bus_gnt,
  input logic              fifo_valid,
  input logic              fifo_eol,
  input logic              term_req,
  input logic              slow_irq,
  input logic              discard_en,
  input logic              bus_req,
  input logic [LINE_W-1:0] lines_dropped
);
  localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

  AST_TERM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !term_req); // R3
  AST_TERM_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_req) |-> $past(tgt_ack)); // R3
  AST_IRQ_WITH_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    slow_irq |-> term_req); // R4
  AST_TERM_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |-> discard_en); // R5
  AST_BUSREQ_IN_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> discard_en); // R8
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_en && lines_dropped == LMAX) |=> lines_dropped == LMAX); // R9
  AST_EXIT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discard_en) |-> $past(bus_gnt) && $past(bus_req)); // R10
  AST_PLAIN_POP_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_en && !(fifo_valid && fifo_eol)) |=> $stable(lines_dropped)); // R12
endmodule

bind ovr_resync_ctrl ovr_resync_checker #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tgt_ack      (tgt_ack),
  .bus_gnt      (bus_gnt),
  .fifo_valid   (fifo_valid),
  .fifo_eol     (fifo_eol),
  .term_req     (term_req),
  .slow_irq     (slow_irq),
  .discard_en   (discard_en),
  .bus_req      (bus_req),
  .lines_dropped(lines_dropped)
);

// File: tb/ovr_resync_ctrl_bench.sv
module ovr_resync_ctrl_bench;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_target = 0, ovf = 0, tgt_ack = 0, bus_gnt = 0;
  logic instr_avail = 0, instr_done = 0, ins_eol = 0;
  logic fifo_valid = 0, fifo_eol = 0;
  logic fifo_ready, term_req, slow_irq, discard_en, tail_drop, bus_req;
  logic [LW-1:0] lines_dropped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovr_resync_ctrl #(.LINE_W(LW)) u_ovr_resync_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_target(wait_target), .ovf(ovf),
    .tgt_ack(tgt_ack), .bus_gnt(bus_gnt), .instr_avail(instr_avail),
    .instr_done(instr_done), .ins_eol(ins_eol), .fifo_valid(fifo_valid),
    .fifo_eol(fifo_eol), .fifo_ready(fifo_ready), .term_req(term_req),
    .slow_irq(slow_irq), .discard_en(discard_en), .tail_drop(tail_drop),
    .bus_req(bus_req), .lines_dropped(lines_dropped)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    chk("R1 term_req", term_req, 0);
    chk("R1 slow_irq", slow_irq, 0);
    chk("R1 discard_en", discard_en, 0);
    chk("R1 fifo_ready", fifo_ready, 0);
    chk("R1 tail_drop", tail_drop, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 lines_dropped", lines_dropped, 0);
  endtask

  task automatic t_ignore_ovf;
    ovf = 1; wait_target = 0;
    step(3);
    chk("R2 discard_en", discard_en, 0);
    chk("R2 term_req", term_req, 0);
    ovf = 0;
  endtask

  task automatic t_terminate;
    wait_target = 1; ovf = 1;
    step();
    ovf = 0;
    step(2);
    chk("R3 no term before ack", term_req, 0);
    chk("R3 no discard before ack", discard_en, 0);
    tgt_ack = 1;
    step();
    tgt_ack = 0; wait_target = 0;
    chk("R3 term pulse", term_req, 1);
    chk("R4 irq pulse", slow_irq, 1);
    chk("R5 discard_en", discard_en, 1);
    chk("R5 fifo_ready", fifo_ready, 1);
    step();
    chk("R3 term one cycle", term_req, 0);
    chk("R4 irq one cycle", slow_irq, 0);
    chk("R5 still discarding", discard_en, 1);
  endtask

  task automatic t_instr_walk;
    instr_avail = 1; instr_done = 1;
    step();
    instr_done = 0;
    chk("R6 discard continues", discard_en, 1);
    chk("R6 tail_drop", tail_drop, 0);
    instr_avail = 0; instr_done = 1;
    step();
    instr_done = 0;
    chk("R7 tail_drop", tail_drop, 1);
    chk("R7 discard continues", discard_en, 1);
  endtask

  task automatic t_plain_pop;
    fifo_valid = 1; fifo_eol = 0;
    step(3);
    chk("R12 count unchanged", lines_dropped, 0);
    chk("R12 no bus_req", bus_req, 0);
    chk("R7 tail_drop holds", tail_drop, 1);
  endtask

  task automatic t_eol_and_exit;
    fifo_eol = 1;
    step();
    fifo_valid = 0; fifo_eol = 0;
    chk("R8 count step", lines_dropped, 1);
    chk("R8 bus_req", bus_req, 1);
    chk("R8 tail_drop clear", tail_drop, 0);
    bus_gnt = 1;
    step();
    chk("R10 grant with mismatch", discard_en, 1);
    ins_eol = 1;
    step();
    ins_eol = 0;
    chk("R10 still in discard", discard_en, 1);
    step();
    chk("R10 exit on match", discard_en, 0);
    chk("R10 bus_req dropped", bus_req, 0);
    bus_gnt = 0;
    step(2);
    chk("R11 count held", lines_dropped, 1);
    chk("R11 ready low after exit", fifo_ready, 0);
  endtask

  task automatic t_saturate;
    wait_target = 1; ovf = 1;
    step();
    wait_target = 0; ovf = 0;
    chk("R11 cleared on arm", lines_dropped, 0);
    tgt_ack = 1;
    step();
    tgt_ack = 0;
    fifo_valid = 1; fifo_eol = 1;
    step(20);
    fifo_valid = 0; fifo_eol = 0;
    chk("R9 saturated", lines_dropped, 15);
    ins_eol = 1;
    step(20);
    ins_eol = 0;
    chk("R9 no wrap", lines_dropped, 15);
    chk("R10 waits for grant", discard_en, 1);
    bus_gnt = 1;
    step();
    bus_gnt = 0;
    chk("R10 exit at saturated match", discard_en, 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step();
    t_reset();
    t_ignore_ovf();
    t_terminate();
    t_instr_walk();
    t_plain_pop();
    t_eol_and_exit();
    t_saturate();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule